// File: doc/BRIEF.md
# Register-Mapped Watchdog Countdown Timer

This block is the watchdog part of a real-time clock register file. Software sees it through a synchronous register port. A mode register chooses the count source and decides whether an expiry drives the system reset line. A value register holds the number of one-second ticks left. Writing a valid count arms the timer. Writing the count again before it runs out acts as the keepalive. If the count runs out, an active-low reset output is pulled low for one tick period.

Writing zero to the value register stops the timer. So does any read of the shared status register at address 0x01, which holds flags for other clock functions. Software that reads that register must write the value register again if it wants the watchdog to keep running. Read data is registered and appears one clock after the read strobe. The serial bus bridge and the other clock functions are outside this block.

Top module: `rtc_wdog`

## Requirements
- R1: While reset is high, and after it is released, the mode register (0x10) reads 0x00, the value register (0x11) reads 0x00 and rst_n_out is high.
- R2: The mode register at address 0x10 stores all 8 written bits and reads them back. Bits [7:6]=2'b11 route an expiry to rst_n_out. Bits [1:0]=2'b10 select tick_1hz as the count source.
- R3: Writing a value from 2 to 255 to address 0x11 loads the counter and starts it. A read of 0x11 returns the ticks left, and rdata is valid on the cycle after the read strobe.
- R4: While the counter is nonzero and the source bits are 2'b10, each clock with tick_1hz high lowers the count by one.
- R5: Writing a valid value to 0x11 while the counter is running reloads the counter with the new value.
- R6: With bits [7:6]=2'b11, the tick that takes the count from 1 to 0 drives rst_n_out low from the following cycle. The output stays low until the next tick_1hz pulse. The timer stays stopped and produces no further pulse.
- R7: Writing 0 to 0x11 stops the counter at 0, and no reset pulse follows.
- R8: Writing 1 to 0x11 has no effect on the counter, whether it is stopped or running.
- R9: A read of address 0x01 returns 0x00 and stops the counter at 0, and no reset pulse follows.
- R10: When the source bits are not 2'b10, ticks leave the count unchanged.
- R11: When bits [7:6] are not 2'b11, an expiry stops the counter at 0 and leaves rst_n_out high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-clock pulse once per second |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rst_n_out | output | 1 | Active-low reset request |

## Verification
The counter is loaded with several values: the minimum count of 2 (with watchdog routing off), 3, 5, and a reload to 7. Comparing the count read back with the number of ticks applied separates correct decrementing from loss or doubling of ticks. Four stimuli that could each disturb the count are applied: a zero write, a write of 1, a status-register read, and ticks with a different source selected. Each shows whether that stimulus stops the timer, is ignored, or wrongly releases a reset pulse. The expiry pattern samples rst_n_out the tick before zero, at zero and one tick later, which fixes both the edge and the width of the pulse.

// File: rtl/rtc_wdog_pkg.sv
package rtc_wdog_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] ADR_STATUS = 5'h01;
  localparam logic [ADDR_W-1:0] ADR_MODE   = 5'h10;
  localparam logic [ADDR_W-1:0] ADR_COUNT  = 5'h11;
  localparam logic [1:0] SRC_1HZ  = 2'b10;
  localparam logic [1:0] FN_RESET = 2'b11;
endpackage

// File: rtl/rtc_wdog_mode.sv
module rtc_wdog_mode
  import rtc_wdog_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] din,
  input  logic          tick_raw,
  output logic [DW-1:0] mode_q,
  output logic          tick_en,
  output logic          route_rst
);
  always_ff @(posedge clk) begin
    if (rst) mode_q <= '0;
    else if (we) mode_q <= din;
  end

  assign tick_en   = tick_raw && (mode_q[1:0] == SRC_1HZ);
  assign route_rst = (mode_q[DW-1:DW-2] == FN_RESET);
endmodule

// File: rtl/rtc_wdog_count.sv
module rtc_wdog_count #(
  parameter int DW      = 8,
  parameter int VAL_MIN = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          halt,
  input  logic [DW-1:0] din,
  input  logic          tick_en,
  input  logic          tick_raw,
  input  logic          route_rst,
  output logic [DW-1:0] count_q,
  output logic          pulse_q
);
  localparam logic [DW-1:0] ONE = DW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (pulse_q && tick_raw) pulse_q <= 1'b0;
      if (load) begin
        count_q <= din;
      end else if (halt) begin
        count_q <= '0;
      end else if (count_q != '0 && tick_en) begin
        count_q <= count_q - ONE;
        if (count_q == ONE && route_rst) pulse_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_wdog.sv
module rtc_wdog
  import rtc_wdog_pkg::*;
#(
  parameter int AW      = ADDR_W,
  parameter int DW      = DATA_W,
  parameter int VAL_MIN = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_1hz,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rst_n_out
);
  localparam logic [DW-1:0] MIN_V = DW'(VAL_MIN);

  logic [DW-1:0] mode_q, count_q;
  logic          tick_en, route_rst, pulse_q;
  logic          we_mode, we_cnt, cnt_load, cnt_halt;

  assign we_mode  = wr_en && (addr == ADR_MODE);
  assign we_cnt   = wr_en && (addr == ADR_COUNT);
  assign cnt_load = we_cnt && (wdata >= MIN_V);
  assign cnt_halt = (we_cnt && (wdata == '0)) || (rd_en && (addr == ADR_STATUS));

  rtc_wdog_mode #(.DW(DW)) u_mode (
    .clk(clk), .rst(rst), .we(we_mode), .din(wdata), .tick_raw(tick_1hz),
    .mode_q(mode_q), .tick_en(tick_en), .route_rst(route_rst)
  );

  rtc_wdog_count #(.DW(DW), .VAL_MIN(VAL_MIN)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .halt(cnt_halt), .din(wdata),
    .tick_en(tick_en), .tick_raw(tick_1hz), .route_rst(route_rst),
    .count_q(count_q), .pulse_q(pulse_q)
  );

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        ADR_MODE:  rdata <= mode_q;
        ADR_COUNT: rdata <= count_q;
        default:   rdata <= '0;
      endcase
    end
  end

  assign rst_n_out = ~pulse_q;
endmodule

// File: rtl/rtc_wdog_chk.sv
module rtc_wdog_chk #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          tick_1hz,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] count_q,
  input logic          rst_n_out
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (rst_n_out && count_q == '0)); // R1
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 5'h11 && wdata >= 8'd2) |=> count_q == $past(wdata)); // R5
  AST_ZERO_WRITE_STOPS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 5'h11 && wdata == '0) |=> count_q == '0); // R7
  AST_STATUS_READ_STOPS: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 5'h01) |=> count_q == '0); // R9
  AST_IDLE_HOLDS_COUNT: assert property (@(posedge clk) disable iff (rst)
    (!tick_1hz && !wr_en && !rd_en) |=> $stable(count_q)); // R4
  AST_PULSE_FROM_EXPIRY: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_n_out) |-> ($past(count_q) == 8'd1 && $past(tick_1hz))); // R6
  AST_PULSE_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (!rst_n_out && tick_1hz) |=> rst_n_out); // R6
endmodule

bind rtc_wdog rtc_wdog_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .count_q(count_q), .rst_n_out(rst_n_out)
);

// File: tb/rtc_wdog_bench.sv
module rtc_wdog_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_1hz = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rst_n_out;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_wdog u_rtc_wdog (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rst_n_out(rst_n_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output int v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = int'(rdata);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    int v;
    chk("R1 rst_n_out", int'(rst_n_out), 1);
    rd(5'h10, v); chk("R1 mode reg", v, 0);
    rd(5'h11, v); chk("R1 count reg", v, 0);
  endtask

  task automatic t_mode_reg();
    int v;
    wr(5'h10, 8'h5A); rd(5'h10, v); chk("R2 readback 5A", v, 8'h5A);
    wr(5'h10, 8'hC2); rd(5'h10, v); chk("R2 readback C2", v, 8'hC2);
  endtask

  task automatic t_count_and_reload();
    int v;
    wr(5'h11, 8'd5); rd(5'h11, v); chk("R3 loaded", v, 5);
    ticks(2); rd(5'h11, v); chk("R4 after 2 ticks", v, 3);
    wr(5'h11, 8'd7); rd(5'h11, v); chk("R5 reload", v, 7);
  endtask

  task automatic t_expiry();
    int v;
    wr(5'h11, 8'd3); ticks(2);
    chk("R6 high before zero", int'(rst_n_out), 1);
    ticks(1);
    chk("R6 low at zero", int'(rst_n_out), 0);
    rd(5'h11, v); chk("R6 stopped", v, 0);
    ticks(1);
    chk("R6 released after one tick", int'(rst_n_out), 1);
    ticks(3);
    chk("R6 no second pulse", int'(rst_n_out), 1);
  endtask

  task automatic t_zero_stop();
    int v;
    wr(5'h11, 8'd4); ticks(1); wr(5'h11, 8'd0);
    rd(5'h11, v); chk("R7 count zero", v, 0);
    ticks(5); chk("R7 no reset", int'(rst_n_out), 1);
  endtask

  task automatic t_one_ignored();
    int v;
    wr(5'h11, 8'd1); rd(5'h11, v); chk("R8 stopped stays 0", v, 0);
    wr(5'h11, 8'd6); wr(5'h11, 8'd1); rd(5'h11, v); chk("R8 running keeps 6", v, 6);
  endtask

  task automatic t_status_read();
    int v;
    rd(5'h01, v); chk("R9 status reads 0", v, 0);
    rd(5'h11, v); chk("R9 count halted", v, 0);
    ticks(8); chk("R9 no reset", int'(rst_n_out), 1);
    wr(5'h11, 8'd3); ticks(3); chk("R9 reload then expiry", int'(rst_n_out), 0);
    ticks(1);
  endtask

  task automatic t_other_source();
    int v;
    wr(5'h10, 8'hC0); wr(5'h11, 8'd4); ticks(6);
    rd(5'h11, v); chk("R10 count frozen", v, 4);
    chk("R10 no reset", int'(rst_n_out), 1);
    wr(5'h11, 8'd0);
  endtask

  task automatic t_no_route();
    int v;
    wr(5'h10, 8'h02); wr(5'h11, 8'd2); ticks(2);
    rd(5'h11, v); chk("R11 expired count", v, 0);
    chk("R11 reset stays high", int'(rst_n_out), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rst_n_out during reset", int'(rst_n_out), 1);
    rst = 1'b0;
    t_reset();
    t_mode_reg();
    t_count_and_reload();
    t_expiry();
    t_zero_stop();
    t_one_ignored();
    t_status_read();
    t_other_source();
    t_no_route();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule